// File: doc/BRIEF.md
# Four-Lane Receive Deskew and Bonding Aligner

This block sits behind four parallel serial receivers. Each receiver hands it one 16-bit decoded word per clock and a flag that says the word is the bonding marker. The transmitter places that marker on every lane in the same transmit cycle. Because the lanes arrive with different delays, the block keeps a short circular history of each lane. It notes the receive cycle in which each lane's marker shows up and then sets a per-lane read delay. After that, every word on the 64-bit output comes from one transmit cycle.

Alignment is checked for as long as the block runs. Once bonded, a marker that leaves the delay lines on some lanes but not on all of them shows that the lanes have drifted. The block then drops its bonded flag, raises a sticky lost flag and starts looking for a new marker set. A request input also throws away the current alignment and restarts acquisition at any time. If the markers of one set are spread over more than four receive cycles, bonding fails and no alignment is taken.

Top module: `lane_bond_deskew`

## Requirements
- R1: While `rst` is high at a clock edge, `bonded`, `out_valid` and `bond_lost` are 0 after that edge.
- R2: `out_valid` stays 0 until bonding completes. It rises one cycle after `bonded` rises and falls one cycle after `bonded` falls.
- R3: Let the first lane's marker be sampled at edge f and the last lane's marker at edge f+k, with k between 0 and 4. Then `bonded` is 1 after edge f+k.
- R4: While bonded, each output lane l (bits 16*l+15..16*l) carries, at every valid cycle, the word sent in the same transmit cycle as the other three lanes. The first valid word is the marker word, and it appears the cycle after the latest lane's marker is sampled.
- R5: A marker spread of 5 or more receive cycles is a failure. `bonded` stays 0 and `bond_lost` is set, at the latest 4 cycles after the first marker.
- R6: While bonded, a marker that leaves the delay lines on some lanes but not all of them clears `bonded` at the next edge and sets `bond_lost`.
- R7: A cycle with `rebond_req` high clears `bonded` at that edge, discards any partly captured marker set and ignores the markers sampled in that cycle. The next complete marker set then realigns the lanes.
- R8: `bond_lost` stays set through re-bond requests until a bonding attempt succeeds or reset is applied.
- R9: While bonded, a marker set that arrives aligned on all four lanes leaves `bonded` at 1 and the data alignment unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Active-high synchronous reset |
| lane_data | input | 64 | Decoded words, lane l in bits 16*l+15..16*l |
| lane_mark | input | 4 | Per-lane marker flag for the word on lane_data |
| rebond_req | input | 1 | Discard alignment and reacquire |
| out_data | output | 64 | Aligned words, same lane order |
| out_valid | output | 1 | out_data holds an aligned word set |
| bonded | output | 1 | Lane delays are set and alignment holds |
| bond_lost | output | 1 | Sticky: bonding failed or alignment broke |

## Verification
A wrong lane delay shows on the very first valid cycle. There the output lanes hold words from different transmit cycles instead of four marker words, so one cycle after the latest marker is enough to tell. Every skew combination of 0 to 5 cycles per lane is swept, and the output's transmit index is compared on each valid cycle. This also exposes a wrong arrival count or a one-off read pointer within a few cycles. Errors in the window counter or the drift detector show up as `bonded` or `bond_lost` holding the wrong value one edge after the marker that should have decided them.

// File: rtl/lane_bond_deskew.sv
module lane_bond_deskew #(
  parameter int LANES    = 4,
  parameter int W        = 16,
  parameter int DEPTH    = 8,
  parameter int MAX_SKEW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*W-1:0] lane_data,
  input  logic [LANES-1:0]   lane_mark,
  input  logic               rebond_req,
  output logic [LANES*W-1:0] out_data,
  output logic               out_valid,
  output logic               bonded,
  output logic               bond_lost
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(MAX_SKEW + 1);

  logic [W:0]         hist [LANES][DEPTH];
  logic [PW-1:0]      wp;
  logic [PW-1:0]      dly [LANES];
  logic [CW-1:0]      arr [LANES];
  logic [CW-1:0]      cnt;
  logic [LANES-1:0]   seen;
  logic [LANES-1:0]   tap_mark;
  logic [LANES*W-1:0] tap_data;
  logic               any_zero_dly;

  wire all_seen = &(seen | lane_mark);
  wire drift    = (|tap_mark) && !(&tap_mark);

  always_comb begin
    any_zero_dly = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      {tap_mark[l], tap_data[l*W +: W]} = hist[l][wp - PW'(1) - dly[l]];
      if (dly[l] == '0) any_zero_dly = 1'b1;
    end
  end

  always_ff @(posedge clk)
    for (int l = 0; l < LANES; l++)
      hist[l][wp] <= {lane_mark[l], lane_data[l*W +: W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      cnt       <= '0;
      seen      <= '0;
      bonded    <= 1'b0;
      bond_lost <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int l = 0; l < LANES; l++) begin
        dly[l] <= '0;
        arr[l] <= '0;
      end
    end else begin
      wp        <= wp + PW'(1);
      out_data  <= tap_data;
      out_valid <= bonded;
      if (rebond_req) begin
        bonded <= 1'b0;
        seen   <= '0;
        cnt    <= '0;
      end else if (bonded) begin
        if (drift) begin
          bonded    <= 1'b0;
          bond_lost <= 1'b1;
          seen      <= '0;
          cnt       <= '0;
        end
      end else if (all_seen) begin
        for (int l = 0; l < LANES; l++)
          dly[l] <= seen[l] ? PW'(cnt - arr[l]) : '0;
        bonded    <= 1'b1;
        bond_lost <= 1'b0;
        seen      <= '0;
        cnt       <= '0;
      end else if (seen == '0) begin
        if (|lane_mark) begin
          seen <= lane_mark;
          cnt  <= CW'(1);
          for (int l = 0; l < LANES; l++) arr[l] <= '0;
        end
      end else if (cnt == CW'(MAX_SKEW)) begin
        bond_lost <= 1'b1;
        seen      <= '0;
        cnt       <= '0;
      end else begin
        for (int l = 0; l < LANES; l++)
          if (lane_mark[l] && !seen[l]) arr[l] <= cnt;
        seen <= seen | lane_mark;
        cnt  <= cnt + CW'(1);
      end
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!bonded && !out_valid && !bond_lost));

  p_valid_needs_bond_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(bonded));

  p_rebond_drops_r7: assert property (@(posedge clk) disable iff (rst)
    rebond_req |=> !bonded);

  p_lost_not_bonded_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(bond_lost) |-> !bonded);

  p_bond_clears_lost_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(bonded) |-> !bond_lost);

  p_window_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(MAX_SKEW));

  p_latest_lane_undelayed_r4: assert property (@(posedge clk) disable iff (rst)
    bonded |-> any_zero_dly);

  always_ff @(posedge clk)
    if (!rst && bonded)
      for (int l = 0; l < LANES; l++)
        p_delay_bound_r4: assert (dly[l] <= PW'(MAX_SKEW));
endmodule

// File: tb/test_lane_bond_deskew.sv
module test_lane_bond_deskew;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] lane_data;
  logic [3:0]  lane_mark;
  logic        rebond_req;
  logic [63:0] out_data;
  logic        out_valid, bonded, bond_lost;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  lane_bond_deskew i_lane_bond_deskew (
    .clk(clk), .rst(rst), .lane_data(lane_data), .lane_mark(lane_mark),
    .rebond_req(rebond_req), .out_data(out_data), .out_valid(out_valid),
    .bonded(bonded), .bond_lost(bond_lost));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual %0d expected <150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic [3:0] m, input logic rb);
    @(negedge clk);
    lane_mark  = m;
    rebond_req = rb;
    lane_data  = '0;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lane_mark = '0; rebond_req = 1'b0; lane_data = '0;
    @(posedge clk); @(posedge clk); #1;
    chk(!bonded && !out_valid && !bond_lost, "R1 reset",
        int'({bonded, out_valid, bond_lost}), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // lane l sees transmit word t at receive cycle t + a[l]; markers at t=2 (and t=12 if two)
  task automatic run_pattern(input int a0, a1, a2, a3, input bit two, input bit lost_in);
    int a[4];
    int mx, mn, c;
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    mx = a0; mn = a0;
    for (int l = 1; l < 4; l++) begin
      if (a[l] > mx) mx = a[l];
      if (a[l] < mn) mn = a[l];
    end
    for (c = 0; c < 22; c++) begin
      @(negedge clk);
      rebond_req = 1'b0;
      for (int l = 0; l < 4; l++) begin
        int t;
        t = c - a[l];
        lane_data[l*16 +: 16] = (t >= 0) ? 16'((l << 12) | (t & 12'hFFF)) : 16'h0;
        lane_mark[l] = (t == 2) || (two && t == 12);
      end
      @(posedge clk);
      #1;
      if (mx - mn <= 4) begin
        chk(bonded == (c >= 2 + mx), "R3 bonded timing", int'(bonded), int'(c >= 2 + mx));
        chk(out_valid == (c >= 3 + mx), "R2 valid timing", int'(out_valid), int'(c >= 3 + mx));
        chk(bond_lost == ((c >= 2 + mx) ? 1'b0 : lost_in), "R8 lost flag",
            int'(bond_lost), int'((c >= 2 + mx) ? 1'b0 : lost_in));
        if (c >= 3 + mx)
          for (int l = 0; l < 4; l++) begin
            int e;
            e = (l << 12) | ((c - 1 - mx) & 12'hFFF);
            chk(int'(out_data[l*16 +: 16]) == e, two ? "R9 R4 aligned data" : "R4 aligned data",
                int'(out_data[l*16 +: 16]), e);
          end
      end else begin
        chk(!bonded && !out_valid, "R5 no bond on wide spread", int'(bonded), 0);
        if (c >= 2 + mn + 4)
          chk(bond_lost, "R5 failure flagged", int'(bond_lost), 1);
      end
    end
    @(negedge clk);
    lane_mark = '0;
  endtask

  initial begin
    rst = 1'b1; lane_mark = '0; rebond_req = 1'b0; lane_data = '0;

    // R3 R4 R5 R2: every per-lane skew 0..5
    for (int a0 = 0; a0 < 6; a0++)
      for (int a1 = 0; a1 < 6; a1++)
        for (int a2 = 0; a2 < 6; a2++)
          for (int a3 = 0; a3 < 6; a3++) begin
            do_reset();
            run_pattern(a0, a1, a2, a3, 1'b0, 1'b0);
          end

    // R9: second aligned marker set while bonded
    do_reset();
    run_pattern(3, 0, 4, 1, 1'b1, 1'b0);

    // R6: marker on one lane only while bonded
    do_reset();
    run_pattern(0, 0, 0, 0, 1'b0, 1'b0);
    tick(4'b0001, 1'b0);
    chk(bonded, "R6 still bonded at marker edge", int'(bonded), 1);
    tick(4'b0000, 1'b0);
    chk(!bonded && bond_lost, "R6 drift detected", int'({bonded, bond_lost}), 1);
    tick(4'b0000, 1'b0);
    chk(!out_valid, "R2 R6 valid drops", int'(out_valid), 0);

    // R7: rebond request drops bond, ignores markers in that cycle, realigns
    do_reset();
    run_pattern(0, 1, 2, 3, 1'b0, 1'b0);
    tick(4'b1111, 1'b1);
    chk(!bonded, "R7 rebond drops bond", int'(bonded), 0);
    tick(4'b0000, 1'b0);
    chk(!bonded, "R7 markers in rebond cycle ignored", int'(bonded), 0);
    run_pattern(3, 0, 4, 1, 1'b0, 1'b0);

    // R7: rebond discards a partial set
    do_reset();
    tick(4'b0011, 1'b0);
    tick(4'b0000, 1'b1);
    tick(4'b1100, 1'b0);
    tick(4'b0000, 1'b0);
    chk(!bonded, "R7 partial set discarded", int'(bonded), 0);

    // R8: failure stays flagged through rebond, cleared by a good bond
    do_reset();
    run_pattern(0, 5, 0, 0, 1'b0, 1'b0);
    tick(4'b0000, 1'b1);
    chk(bond_lost, "R8 lost survives rebond", int'(bond_lost), 1);
    run_pattern(2, 2, 0, 1, 1'b0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule